// File: doc/BRIEF.md
# Modem Line Status Change Detector

This block watches four incoming modem handshake lines (carrier detect, ring indicator, data-set-ready and clear-to-send). It brings each line into the local clock domain and publishes its present level. It also keeps a sticky change flag per line, which software clears by writing a one to it. Carrier detect, data-set-ready and clear-to-send flag any transition. The ring indicator flags only the edge on which it goes inactive, that is, from one to zero. Whenever a flag goes from clear to set, a single-cycle event pulse is sent to the interrupt unit.

The same register port holds the two outgoing handshake lines (terminal-ready and request-to-send) and an enable for automatic flow control. When that enable is set, the transmit-allowed output follows the synchronised clear-to-send level. The two registers sit at offsets that the driver software relies on: 0x24 for control and 0x28 for status. Reads are registered, and the read data holds its value between read strobes.

Top module: `modem_sig_watch`

## Requirements
- R1: After reset, all change flags, `dtr_out`, `rts_out`, the flow-control enable, `chg_event` and `bus_rdata` are 0, and `tx_allowed` is 1.
- R2: Status register 0x28 bits 4 (CTS), 5 (DSR), 6 (RI) and 7 (DCD) report the line levels after a two-flop synchroniser. A level change at the pins is readable no later than four clock cycles after it occurs.
- R3: Status bits 0 (CTS changed), 1 (DSR changed) and 3 (DCD changed) are set by a rising edge and also by a falling edge of their synchronised line.
- R4: Status bit 2 (RI trailing edge) sets only when RI goes from 1 to 0. A rising edge of RI leaves it unchanged.
- R5: Writing 0x28 clears every change flag whose bit 0..3 in the write data is one. Flags written with zero keep their value.
- R6: If a flag's set condition and its clear write fall in the same cycle, the flag ends up set and an event is produced.
- R7: `chg_event` is a one-cycle pulse for each cycle in which at least one flag goes from 0 to 1. A new edge on a line whose flag is already set produces no pulse.
- R8: Control register 0x24 bit 0 drives `dtr_out`, bit 1 drives `rts_out` and bit 5 enables flow control. All three read back at the same positions, and the other bits read as zero.
- R9: Status bit 8 reads the flow-control enable.
- R10: `tx_allowed` equals the synchronised CTS level while flow control is enabled, and is 1 while it is disabled.
- R11: Writes to status bits 4..31 change no level, enable or output.
- R12: `bus_rdata` changes only in the cycle after a read strobe. A read of any offset other than 0x24 or 0x28 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| dcd_in | input | 1 | Carrier detect line |
| ri_in | input | 1 | Ring indicator line |
| dsr_in | input | 1 | Data-set-ready line |
| cts_in | input | 1 | Clear-to-send line |
| dtr_out | output | 1 | Terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| tx_allowed | output | 1 | Transmitter permission |
| chg_event | output | 1 | One-cycle change event to the interrupt unit |

## Verification
The bench targets the rising edge of the ring indicator, which must not set its flag; a design that treated RI like the other lines would flag incoming rings early. It lands a clear write exactly on the cycle a flag sets. A design that gave the clear priority would lose that edge and its event without any trace. It also repeats edges on a line whose flag is already set: a design that pulsed on every edge would raise a second interrupt for a change that software has not yet acknowledged. Finally, it writes junk to the upper status bits and to the zero bits of the clear mask. A decoder that was too wide would then alter the enable or wipe out flags that are still pending.

// File: rtl/modem_sig_pkg.sv
package modem_sig_pkg;
  localparam int NLINES      = 4;
  // line index = position of the change flag in the status word
  localparam int IDX_CTS     = 0;
  localparam int IDX_DSR     = 1;
  localparam int IDX_RI      = 2;
  localparam int IDX_DCD     = 3;
  localparam int CTL_DTR_BIT = 0;
  localparam int CTL_RTS_BIT = 1;
  localparam int CTL_AFC_BIT = 5;
  localparam int ST_LVL_LSB  = 4;
  localparam int ST_AFC_BIT  = 8;

  typedef enum logic [0:0] {EDGE_ANY, EDGE_FALL} edge_kind_e;

  function automatic edge_kind_e kind_of(input int idx);
    return (idx == IDX_RI) ? EDGE_FALL : EDGE_ANY;
  endfunction
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta
  import modem_sig_pkg::*;
#(
  parameter int N = NLINES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         evt
);
  logic [N-1:0] lvl_d;
  logic [N-1:0] set_c;
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    if (kind_of(i) == EDGE_FALL) begin : g_fall
      assign set_c[i] = lvl_d[i] & ~lvl[i];
    end else begin : g_any
      assign set_c[i] = lvl_d[i] ^ lvl[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d  <= '0;
      flag_q <= '0;
      evt    <= 1'b0;
    end else begin
      lvl_d  <= lvl;
      flag_q <= set_c | (flag_q & ~clr);
      evt    <= |(set_c & ~flag_q);
    end
  end

  assign flags = flag_q;

  // R7
  evt_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    evt |-> |(flag_q & ~$past(flag_q)));
  // R7
  rise_gives_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & ~$past(flag_q))) |-> evt);
  // R4
  ri_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[IDX_RI]) |-> ($past(lvl_d[IDX_RI]) && !$past(lvl[IDX_RI])));
  // R5
  clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    (|(~flag_q & $past(flag_q))) |-> |($past(clr) & $past(flag_q) & ~flag_q));
endmodule

// File: rtl/modem_regs.sv
module modem_regs
  import modem_sig_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int N       = NLINES,
  parameter int CTL_OFS = 'h24,
  parameter int STS_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N-1:0]      lvl,
  input  logic [N-1:0]      flags,
  output logic [N-1:0]      clr,
  output logic              dtr_out,
  output logic              rts_out,
  output logic              tx_allowed
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_OFS);

  logic afc_q;
  logic [DATA_W-1:0] ctl_word, sts_word;
  logic wr_ctl, wr_sts;

  assign wr_ctl = bus_wr && (bus_addr == A_CTL);
  assign wr_sts = bus_wr && (bus_addr == A_STS);
  assign clr    = wr_sts ? bus_wdata[N-1:0] : '0;

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_DTR_BIT] = dtr_out;
    ctl_word[CTL_RTS_BIT] = rts_out;
    ctl_word[CTL_AFC_BIT] = afc_q;
    sts_word = '0;
    sts_word[N-1:0] = flags;
    sts_word[ST_LVL_LSB +: N] = lvl;
    sts_word[ST_AFC_BIT] = afc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dtr_out <= 1'b0;
      rts_out <= 1'b0;
      afc_q   <= 1'b0;
    end else if (wr_ctl) begin
      dtr_out <= bus_wdata[CTL_DTR_BIT];
      rts_out <= bus_wdata[CTL_RTS_BIT];
      afc_q   <= bus_wdata[CTL_AFC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tx_allowed <= 1'b1;
    else     tx_allowed <= afc_q ? lvl[IDX_CTS] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      if (bus_addr == A_CTL)      bus_rdata <= ctl_word;
      else if (bus_addr == A_STS) bus_rdata <= sts_word;
      else                        bus_rdata <= '0;
    end
  end

  // R10
  afc_off_tx_chk: assert property (@(posedge clk) disable iff (rst)
    !afc_q |=> tx_allowed);
  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R8
  dtr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (dtr_out == $past(bus_wdata[CTL_DTR_BIT])));
  // R11
  sts_wr_keeps_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !wr_ctl) |=> ($stable(dtr_out) && $stable(rts_out) && $stable(afc_q)));
endmodule

// File: rtl/modem_sig_watch.sv
module modem_sig_watch
  import modem_sig_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              dcd_in,
  input  logic              ri_in,
  input  logic              dsr_in,
  input  logic              cts_in,
  output logic              dtr_out,
  output logic              rts_out,
  output logic              tx_allowed,
  output logic              chg_event
);
  logic [NLINES-1:0] raw, lvl, flags, clr;

  always_comb begin
    raw = '0;
    raw[IDX_CTS] = cts_in;
    raw[IDX_DSR] = dsr_in;
    raw[IDX_RI]  = ri_in;
    raw[IDX_DCD] = dcd_in;
  end

  modem_sync #(.W(NLINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw), .q_out(lvl)
  );

  modem_delta #(.N(NLINES)) u_delta (
    .clk(clk), .rst(rst), .lvl(lvl), .clr(clr), .flags(flags), .evt(chg_event)
  );

  modem_regs #(.ADDR_W(ADDR_W), .DATA_W(32), .N(NLINES)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .lvl(lvl), .flags(flags), .clr(clr), .dtr_out(dtr_out),
    .rts_out(rts_out), .tx_allowed(tx_allowed)
  );
endmodule

// File: tb/modem_sig_watch_test.sv
`timescale 1ns/1ps
module modem_sig_watch_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  lines = '0; // [0]=CTS [1]=DSR [2]=RI [3]=DCD
  logic dtr_out, rts_out, tx_allowed, chg_event;

  modem_sig_watch uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dcd_in(lines[3]), .ri_in(lines[2]), .dsr_in(lines[1]), .cts_in(lines[0]),
    .dtr_out(dtr_out), .rts_out(rts_out), .tx_allowed(tx_allowed),
    .chg_event(chg_event)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, evt_cnt = 0, exp_evt = 0;
  logic [3:0] m_lv = '0, m_fl = '0;
  logic m_afc = 0, m_dtr = 0, m_rts = 0;

  always @(negedge clk) if (!rst && chg_event) evt_cnt++;

  function automatic logic [31:0] exp_status();
    return {23'b0, m_afc, m_lv, m_fl};
  endfunction
  function automatic logic [31:0] exp_ctl();
    return {26'b0, m_afc, 3'b0, m_rts, m_dtr};
  endfunction
  function automatic logic exp_tx();
    return m_afc ? m_lv[0] : 1'b1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // flip one line and update the model flags and expected events
  task automatic flip(int i);
    logic cond;
    cond = (i == 2) ? (m_lv[i] == 1'b1) : 1'b1; // RI: only 1->0
    if (cond && !m_fl[i]) exp_evt++;
    if (cond) m_fl[i] = 1'b1;
    m_lv[i] = ~m_lv[i];
    lines[i] = m_lv[i];
  endtask

  task automatic rd_status(string req);
    logic [31:0] d;
    rd(6'h28, d);
    chk(req, d, exp_status());
  endtask

  initial begin
    logic [31:0] d, hold;
    void'($urandom(32'h00C0FFEE));
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 dtr", {31'b0, dtr_out}, 0);
    chk("R1 rts", {31'b0, rts_out}, 0);
    chk("R1 tx_allowed", {31'b0, tx_allowed}, 1);
    chk("R1 event", evt_cnt, 0);
    rd_status("R1 status");

    // R4 rising RI has no effect, falling sets
    flip(2); idle(4);
    rd_status("R4 RI rise ignored");
    chk("R4 no event on rise", evt_cnt, exp_evt);
    flip(2); idle(4);
    rd_status("R4 RI fall sets");
    chk("R4 event on fall", evt_cnt, exp_evt);

    // R3 each of CTS/DSR/DCD flags on rise and on fall
    wr(6'h28, 32'hF); m_fl = '0; idle(2);
    for (int i = 0; i < 4; i++) begin
      if (i == 2) continue;
      flip(i); idle(4);
      rd_status("R3 rise sets flag");
      wr(6'h28, 32'h1 << i); m_fl[i] = 1'b0; idle(1);
      flip(i); idle(4);
      rd_status("R3 fall sets flag");
      chk("R2 level reported", {28'b0, m_lv}, {28'b0, lines});
    end
    chk("R7 one pulse per set", evt_cnt, exp_evt);

    // R7 repeated edges on an already set flag give no new pulse
    flip(0); idle(4); flip(0); idle(4);
    chk("R7 no pulse while set", evt_cnt, exp_evt);

    // R5 write-zero keeps flags, write-one clears
    wr(6'h28, 32'h0); idle(1);
    rd_status("R5 zero write keeps");
    wr(6'h28, 32'h5); m_fl &= ~4'h5; idle(1);
    rd_status("R5 partial clear");
    wr(6'h28, 32'hF); m_fl = '0; idle(1);

    // R6 clear collides with set: set wins
    flip(1);
    idle(2);
    wr(6'h28, 32'h2);
    idle(3);
    rd_status("R6 set wins over clear");
    chk("R6 event produced", evt_cnt, exp_evt);

    // R8/R9/R10 control register and flow control
    wr(6'h24, 32'hFFFF_FFFF); m_dtr = 1; m_rts = 1; m_afc = 1; idle(3);
    rd(6'h24, d); chk("R8 ctl readback", d, exp_ctl());
    chk("R8 dtr", {31'b0, dtr_out}, 1);
    chk("R8 rts", {31'b0, rts_out}, 1);
    rd_status("R9 afc mirror");
    chk("R10 tx follows cts", {31'b0, tx_allowed}, {31'b0, exp_tx()});
    flip(0); idle(4);
    chk("R10 tx follows cts toggled", {31'b0, tx_allowed}, {31'b0, exp_tx()});

    // R11 junk in upper status bits changes nothing
    wr(6'h28, 32'hFFFF_FFF0); idle(3);
    rd_status("R11 upper bits ignored");
    chk("R11 outputs kept", {29'b0, dtr_out, rts_out, tx_allowed}, {29'b0, m_dtr, m_rts, exp_tx()});

    // R12 unmapped read and rdata hold
    rd(6'h00, d); chk("R12 unmapped reads zero", d, 0);
    rd(6'h28, hold);
    flip(3); idle(5);
    chk("R12 rdata held without read", bus_rdata, hold);

    // random phase
    for (int k = 0; k < 300; k++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: begin flip($urandom_range(0, 3)); idle(4); end
        1: begin
          d = $urandom();
          wr(6'h28, d); m_fl &= ~d[3:0]; idle(2);
        end
        2: begin
          d = $urandom();
          wr(6'h24, d); m_dtr = d[0]; m_rts = d[1]; m_afc = d[5]; idle(3);
          chk("R8 random outputs", {30'b0, dtr_out, rts_out}, {30'b0, m_dtr, m_rts});
        end
        default: rd_status("R2 random status");
      endcase
      chk("R7 random events", evt_cnt, exp_evt);
      chk("R10 random tx", {31'b0, tx_allowed}, {31'b0, exp_tx()});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule